// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver with Processor Holding Register

This block takes a one-wire asynchronous serial stream, such as the output of a keyboard controller, and turns it into bytes that an 8-bit processor reads over a small read-only register port. A free-running divider turns the system clock into an oversampling tick. A frame engine finds the falling edge of a start bit and confirms it at mid-bit. It then samples eight data bits, least significant first, at the middle of each bit and checks the stop bit.

A byte that arrives with a good stop bit is copied in one step into a holding register, and a new-data flag is raised. The processor can read the holding register at any time. A read in mid-frame returns the previous contents and never a byte that is only partly shifted in. Reading the data register hands over the byte and then empties the register and the flag. A status register reports the new-data flag, an overrun bit and a framing-error bit.

With the default parameters (16 ticks per bit, 32 system clocks per tick) a 28.332 MHz clock gives about 55.3 kbaud. That is close enough to a 55.56 kbaud sender.

Top module: `rx_hold_port`

## Requirements
- R1: A frame is a low start bit, eight data bits and a high stop bit, each lasting OVS*CLK_DIV clocks. The first data bit received lands in bit 0 of the byte that is read back.
- R2: A frame with a good stop bit sets status bit 0 (new data). Reading the status register (addr=1) does not clear that bit.
- R3: A data read is cs=1, rd=1, addr=0 across a rising edge. It returns the held byte. After it the holding register reads 0 and status bits 0 and 1 are clear, until another byte completes.
- R4: The holding register changes only when a frame completes or a data read clears it. A data read taken in mid-frame returns the previous byte.
- R5: If the line is high again when the start bit is rechecked at mid-bit, no byte is produced and the receiver waits for the next falling edge.
- R6: A frame whose stop bit samples low is discarded: neither the data nor status bit 0 change. Status bit 2 (framing error) is set, and it clears after one status read.
- R7: A byte that completes while status bit 0 is still set overwrites the holding register and sets status bit 1 (overrun).
- R8: If a data read falls on the same clock edge as a byte load, the new byte is kept, status bit 0 stays set and status bit 1 stays clear. The read returns the old byte.
- R9: rdata is 0 whenever cs and rd are not both high. An rd strobe with cs low clears nothing.
- R10: After reset the status and data registers both read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| cs | input | 1 | Chip select from the processor bus |
| rd | input | 1 | Read strobe; one read per clock edge with cs high |
| addr | input | 1 | Register select: 0 data, 1 status |
| rdata | output | 8 | Read data, 0 when not selected |

## Verification
The hardest case to reach from the ports is a data read that lands on exactly the same edge as the byte load. The load cycle depends on the phase of the free-running divider and on the synchronizer delay. The bench starts every frame on a clock count that is a multiple of the bit period, so that phase repeats from frame to frame. On one calibration frame it holds a status read open and counts cycles from the start edge until the new-data bit appears. On the collision frame it then issues the data read one cycle earlier, on the load edge itself.

// File: rtl/rxh_pkg.sv
// Shared definitions for the serial byte receiver.
// Assumes the status register is at least three bits wide.
package rxh_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_START = 2'd1,
        S_DATA  = 2'd2,
        S_STOP  = 2'd3
    } rx_state_t;

    localparam int ST_NEW  = 0;  // new byte waiting
    localparam int ST_OVR  = 1;  // byte overwritten before read
    localparam int ST_FERR = 2;  // stop bit sampled low
endpackage

// File: rtl/rxh_tick.sv
// Oversampling tick generator: one-cycle pulse every DIV system clocks.
// Free-running from reset; assumes DIV >= 1.
module rxh_tick #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            // Every cycle is a tick once out of reset.
            always_ff @(posedge clk) begin
                if (!rst_n) tick <= 1'b0;
                else        tick <= 1'b1;
            end
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;
            // Count to DIV-1 and pulse on wrap.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt  <= '0;
                    tick <= 1'b0;
                end else if (cnt == CW'(DIV - 1)) begin
                    cnt  <= '0;
                    tick <= 1'b1;
                end else begin
                    cnt  <= cnt + 1'b1;
                    tick <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/rxh_sync.sv
// Multi-flop synchronizer for the asynchronous serial line.
// Resets to the idle (high) level; assumes STAGES >= 2.
module rxh_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] ff;
    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) ff <= '1;
        else        ff <= {ff[STAGES-2:0], din};
    end
    assign dout = ff[STAGES-1];
endmodule

// File: rtl/rxh_frame.sv
// Frame engine: start detection, mid-bit start check, LSB-first data
// shift and stop check. Emits one-cycle done_ok or done_bad pulses;
// the assembled byte is on byte_q. Assumes a synchronized input line.
module rxh_frame
    import rxh_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          line,
    output logic          done_ok,
    output logic          done_bad,
    output logic [DW-1:0] byte_q
);
    localparam int OW  = $clog2(OVS);
    localparam int BW  = $clog2(DW);
    localparam int MID = OVS / 2 - 1;

    rx_state_t     st;
    logic [OW-1:0] ovs_cnt;
    logic [BW-1:0] bit_cnt;
    logic [DW-1:0] shreg;

    // Step the frame state machine once per oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            ovs_cnt  <= '0;
            bit_cnt  <= '0;
            shreg    <= '0;
            done_ok  <= 1'b0;
            done_bad <= 1'b0;
        end else begin
            done_ok  <= 1'b0;
            done_bad <= 1'b0;
            if (tick) begin
                case (st)
                    S_IDLE: begin
                        if (!line) begin
                            st      <= S_START;
                            ovs_cnt <= '0;
                        end
                    end
                    S_START: begin
                        if (ovs_cnt == OW'(MID)) begin
                            if (line) begin
                                st <= S_IDLE;
                            end else begin
                                st      <= S_DATA;
                                ovs_cnt <= '0;
                                bit_cnt <= '0;
                            end
                        end else begin
                            ovs_cnt <= ovs_cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (ovs_cnt == OW'(OVS - 1)) begin
                            ovs_cnt <= '0;
                            shreg   <= {line, shreg[DW-1:1]};
                            if (bit_cnt == BW'(DW - 1)) st <= S_STOP;
                            else                        bit_cnt <= bit_cnt + 1'b1;
                        end else begin
                            ovs_cnt <= ovs_cnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (ovs_cnt == OW'(OVS - 1)) begin
                            ovs_cnt <= '0;
                            st      <= S_IDLE;
                            if (line) done_ok  <= 1'b1;
                            else      done_bad <= 1'b1;
                        end else begin
                            ovs_cnt <= ovs_cnt + 1'b1;
                        end
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    assign byte_q = shreg;
endmodule

// File: rtl/rxh_hold.sv
// Holding register and status flags on the processor side.
// Loads only on a good frame end; a data read clears the byte, the
// new flag and overrun; a status read clears the framing error.
// A load on the same edge as a data read wins.
module rxh_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_ok,
    input  logic          load_bad,
    input  logic [DW-1:0] byte_in,
    input  logic          rd_data,
    input  logic          rd_stat,
    output logic [DW-1:0] hold_q,
    output logic          new_q,
    output logic          ovr_q,
    output logic          ferr_q
);
    // Holding byte: load at frame end, clear on data read.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (load_ok) hold_q <= byte_in;
        else if (rd_data) hold_q <= '0;
    end

    // New-data flag: set by load, cleared by a data read.
    always_ff @(posedge clk) begin
        if (!rst_n)       new_q <= 1'b0;
        else if (load_ok) new_q <= 1'b1;
        else if (rd_data) new_q <= 1'b0;
    end

    // Overrun: load over an unread byte, cleared by a data read.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ovr_q <= 1'b0;
        else if (load_ok && new_q && !rd_data) ovr_q <= 1'b1;
        else if (rd_data)                     ovr_q <= 1'b0;
    end

    // Framing error: set by a bad stop bit, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)        ferr_q <= 1'b0;
        else if (load_bad) ferr_q <= 1'b1;
        else if (rd_stat)  ferr_q <= 1'b0;
    end
endmodule

// File: rtl/rx_hold_port.sv
// Top level: serial byte receiver with a processor read port.
// Register 0 is the data byte, register 1 is status. rdata is
// combinational and 0 unless cs and rd are both high.
module rx_hold_port
    import rxh_pkg::*;
#(
    parameter int CLK_DIV = 32,
    parameter int OVS     = 16,
    parameter int DW      = 8,
    parameter int SYNC_FF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_line,
    input  logic          cs,
    input  logic          rd,
    input  logic          addr,
    output logic [DW-1:0] rdata
);
    logic          tick;
    logic          line_s;
    logic          frm_ok;
    logic          frm_bad;
    logic [DW-1:0] frm_byte;
    logic [DW-1:0] hold_q;
    logic          new_flag;
    logic          ovr_flag;
    logic          ferr_flag;
    logic          rd_data;
    logic          rd_stat;
    logic [DW-1:0] status;

    assign rd_data = cs && rd && !addr;
    assign rd_stat = cs && rd && addr;

    rxh_tick #(.DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    rxh_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
    );

    rxh_frame #(.OVS(OVS), .DW(DW)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_s),
        .done_ok(frm_ok), .done_bad(frm_bad), .byte_q(frm_byte)
    );

    rxh_hold #(.DW(DW)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .load_ok(frm_ok), .load_bad(frm_bad), .byte_in(frm_byte),
        .rd_data(rd_data), .rd_stat(rd_stat),
        .hold_q(hold_q), .new_q(new_flag), .ovr_q(ovr_flag), .ferr_q(ferr_flag)
    );

    // Pack the status flags into their bit positions.
    always_comb begin
        status          = '0;
        status[ST_NEW]  = new_flag;
        status[ST_OVR]  = ovr_flag;
        status[ST_FERR] = ferr_flag;
    end

    // Read mux: selected register or zero.
    always_comb begin
        rdata = '0;
        if (cs && rd) rdata = addr ? status : hold_q;
    end
endmodule

// File: rtl/rxh_checker.sv
// Assertion checker for rx_hold_port, attached by bind below.
module rxh_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs,
    input logic          rd,
    input logic          addr,
    input logic [DW-1:0] rdata,
    input logic          frm_ok,
    input logic          frm_bad,
    input logic [DW-1:0] hold_q,
    input logic          new_flag,
    input logic          ovr_flag,
    input logic          ferr_flag
);
    logic rd_d;
    assign rd_d = cs && rd && !addr;

    p_one_outcome_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_ok && frm_bad));

    p_flag_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ok |=> new_flag);

    p_read_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_d && !frm_ok) |=> (!new_flag && !ovr_flag && hold_q == '0));

    p_hold_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_ok && !rd_d) |=> $stable(hold_q));

    p_bad_keeps_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_bad && !rd_d) |=> (ferr_flag && $stable(hold_q)));

    p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_ok && new_flag && !rd_d) |=> ovr_flag);

    p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_ok && rd_d) |=> (new_flag && !ovr_flag));

    p_quiet_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd) |-> (rdata == '0));
endmodule

bind rx_hold_port rxh_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .addr(addr), .rdata(rdata),
    .frm_ok(frm_ok), .frm_bad(frm_bad), .hold_q(hold_q),
    .new_flag(new_flag), .ovr_flag(ovr_flag), .ferr_flag(ferr_flag)
);

// File: tb/sim_rx_hold_port.sv
module sim_rx_hold_port;
    localparam int DIV = 2;
    localparam int OVS = 16;
    localparam int BIT = DIV * OVS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       cs = 1'b0;
    logic       rd = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] rdata;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int load_ofs = 0;
    bit done = 1'b0;
    event go;

    rx_hold_port #(.CLK_DIV(DIV), .OVS(OVS)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
        .cs(cs), .rd(rd), .addr(addr), .rdata(rdata)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One-edge register read; value sampled before the edge.
    task automatic rd_reg(input logic a, output logic [7:0] v);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0; addr = 1'b0;
    endtask

    // Send one frame starting on a bit-period-aligned cycle.
    task automatic send_frame(input logic [7:0] b, input bit good_stop);
        @(negedge clk);
        while (cyc % BIT != 0) @(negedge clk);
        rx_line = 1'b0;
        -> go;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            repeat (BIT) @(negedge clk);
        end
        if (good_stop) begin
            rx_line = 1'b1;
            repeat (BIT) @(negedge clk);
        end else begin
            rx_line = 1'b0;
            repeat (BIT - 8) @(negedge clk);
            rx_line = 1'b1;
            repeat (8) @(negedge clk);
        end
        repeat (BIT) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        @(negedge clk); rd = 1'b1; addr = 1'b1; #1;
        chk("R9 idle bus", rdata, 8'h00);
        @(negedge clk); rd = 1'b0; addr = 1'b0;
        rd_reg(1'b1, v); chk("R10 status after reset", v, 8'h00);
        rd_reg(1'b0, v); chk("R10 data after reset", v, 8'h00);
    endtask

    // Basic byte; also measures the load cycle offset from the start edge.
    task automatic t_basic();
        logic [7:0] v;
        int n = 0;
        fork
            send_frame(8'hA5, 1'b1);
            begin
                @go;
                cs = 1'b1; rd = 1'b1; addr = 1'b1;
                while (n < 20 * BIT) begin
                    @(negedge clk); n++;
                    #1 if (rdata[0]) break;
                end
                cs = 1'b0; rd = 1'b0; addr = 1'b0;
                load_ofs = n;
            end
        join
        rd_reg(1'b1, v); chk("R2 new flag after status reads", v, 8'h01);
        rd_reg(1'b0, v); chk("R1 byte A5", v, 8'hA5);
        rd_reg(1'b1, v); chk("R3 flag cleared by data read", v, 8'h00);
        rd_reg(1'b0, v); chk("R3 second read zero", v, 8'h00);
    endtask

    task automatic t_lsb();
        logic [7:0] v;
        send_frame(8'h01, 1'b1);
        rd_reg(1'b0, v); chk("R1 first bit to bit0", v, 8'h01);
        send_frame(8'h80, 1'b1);
        rd_reg(1'b0, v); chk("R1 last bit to bit7", v, 8'h80);
    endtask

    task automatic t_midframe();
        logic [7:0] v;
        logic [7:0] m;
        send_frame(8'h3C, 1'b1);
        fork
            send_frame(8'hC3, 1'b1);
            begin
                @go;
                repeat (5 * BIT) @(negedge clk);
                rd_reg(1'b0, m);
            end
        join
        chk("R4 mid-frame read old byte", m, 8'h3C);
        rd_reg(1'b0, v); chk("R4 new byte after frame", v, 8'hC3);
    endtask

    task automatic t_false_start();
        logic [7:0] v;
        @(negedge clk);
        while (cyc % BIT != 0) @(negedge clk);
        rx_line = 1'b0;
        repeat (4) @(negedge clk);
        rx_line = 1'b1;
        repeat (3 * BIT) @(negedge clk);
        rd_reg(1'b1, v); chk("R5 no flag after glitch", v, 8'h00);
        rd_reg(1'b0, v); chk("R5 no byte after glitch", v, 8'h00);
        send_frame(8'h5A, 1'b1);
        rd_reg(1'b0, v); chk("R5 next frame still received", v, 8'h5A);
    endtask

    task automatic t_framing();
        logic [7:0] v;
        send_frame(8'hE7, 1'b0);
        rd_reg(1'b1, v); chk("R6 framing error set, no new", v, 8'h04);
        rd_reg(1'b1, v); chk("R6 framing error cleared by status read", v, 8'h00);
        rd_reg(1'b0, v); chk("R6 bad byte discarded", v, 8'h00);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        send_frame(8'h11, 1'b1);
        send_frame(8'h22, 1'b1);
        rd_reg(1'b1, v); chk("R7 new and overrun", v, 8'h03);
        rd_reg(1'b0, v); chk("R7 newest byte kept", v, 8'h22);
        rd_reg(1'b1, v); chk("R3 overrun cleared by data read", v, 8'h00);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        logic [7:0] c;
        send_frame(8'h77, 1'b1);
        fork
            send_frame(8'h99, 1'b1);
            begin
                @go;
                repeat (load_ofs - 1) @(negedge clk);
                cs = 1'b1; rd = 1'b1; addr = 1'b0;
                #1 c = rdata;
                @(negedge clk);
                cs = 1'b0; rd = 1'b0;
            end
        join
        chk("R8 colliding read returns old byte", c, 8'h77);
        rd_reg(1'b1, v); chk("R8 flag kept, no overrun", v, 8'h01);
        rd_reg(1'b0, v); chk("R8 new byte kept", v, 8'h99);
    endtask

    task automatic t_no_cs();
        logic [7:0] v;
        send_frame(8'h4E, 1'b1);
        @(negedge clk); rd = 1'b1; addr = 1'b0; #1;
        chk("R9 rdata zero without cs", rdata, 8'h00);
        @(negedge clk); rd = 1'b0;
        rd_reg(1'b1, v); chk("R9 strobe without cs kept flag", v, 8'h01);
        rd_reg(1'b0, v); chk("R9 strobe without cs kept byte", v, 8'h4E);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_lsb();
        t_midframe();
        t_false_start();
        t_framing();
        t_overrun();
        t_collision();
        t_no_cs();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule